// File: doc/BRIEF.md
# Multiplexed-bus external memory glue

This block sits between an 8031-style microcontroller and one 32 KByte asynchronous SRAM. The microcontroller sends the low address byte and the data byte over one shared port. It sends the high address byte over a separate port. The block captures the low byte while the address strobe is high and drives it to the SRAM's eight least significant address lines. It passes the lower seven bits of the high byte straight through, which gives a 15-bit address.

The block decodes address bit 15 together with the code-fetch strobe and the read and write strobes, and produces active-low chip-enable and output-enable for the SRAM. The SRAM serves both code fetches and data accesses in the lower half of the space.

A write to the upper half does not go to the SRAM. It loads a seven-segment output latch instead. The block also drives a reset output to the microcontroller. That reset stays asserted for a programmable number of clocks after the block itself leaves reset. While it is asserted, the SRAM is kept disabled.

All control inputs are sampled on the block clock. The microcontroller is expected to run from a clock derived from it.

Top module: `mcu_mem_glue`

## Requirements
- R1: The low-address register loads `ad_in` on every clock edge where `ale` is sampled high. It holds its value on every edge where `ale` is sampled low. `sram_lo_addr` shows the register.
- R2: `sram_hi_addr` always equals `hi_addr[6:0]`. Bit 7 of `hi_addr` does not reach the SRAM address.
- R3: `sram_ce_n` is low only when all of the following hold: `hi_addr[7]` is 0, at least one of `psen_n`, `rd_n` or `wr_n` is low, and `mcu_rst` is low.
- R4: `sram_oe_n` is low only when the SRAM is selected as in R3, `psen_n` or `rd_n` is low, and `wr_n` is high. It is never low during a write.
- R5: When all three strobes are high, both `sram_ce_n` and `sram_oe_n` are high.
- R6: A write with `hi_addr[7]` = 1 targets the display latch, and `sram_ce_n` stays high throughout it. On the first clock edge where `wr_n` is sampled high after being sampled low, with `hi_addr[7]` = 1, `seg` loads `ad_in[6:0]`. Bit i of `seg` drives segment i, and 1 means lit.
- R7: A write with `hi_addr[7]` = 0 leaves `seg` unchanged. So does a read or a code fetch with `hi_addr[7]` = 1.
- R8: While `rst_n` is low, `seg` and `sram_lo_addr` are 0 (all segments dark). This takes effect without waiting for a clock.
- R9: `mcu_rst` is high while `rst_n` is low. It stays high for exactly `RST_HOLD` rising clock edges after `rst_n` goes high, then stays low until the next reset.
- R10: While `mcu_rst` is high, `sram_ce_n` and `sram_oe_n` are high whatever the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 8 | Shared low-address/data port as seen by the block |
| ale | input | 1 | Address strobe, high while the low address is on `ad_in` |
| hi_addr | input | 8 | High address byte |
| psen_n | input | 1 | Active-low code-fetch strobe |
| rd_n | input | 1 | Active-low data read strobe |
| wr_n | input | 1 | Active-low data write strobe |
| sram_lo_addr | output | 8 | Captured low address to the SRAM |
| sram_hi_addr | output | 7 | Upper SRAM address bits |
| sram_ce_n | output | 1 | Active-low SRAM chip-enable |
| sram_oe_n | output | 1 | Active-low SRAM output-enable |
| seg | output | 7 | Seven-segment drive, bit i = segment i, 1 = lit |
| mcu_rst | output | 1 | Active-high reset to the microcontroller |

## Verification
A wrong low-address register shows on `sram_lo_addr` one clock after the address strobe. A register that keeps loading after the strobe falls shows at the first data-phase edge, when the data byte replaces the address.

A faulty write-edge detector or select decode shows on `seg` one clock after `wr_n` rises. It shows either as a missed load or as a load from an SRAM write.

Errors in the reset counter show as `mcu_rst` falling one or more edges early or late. Decode errors show at once on the enables, because that path is combinational.

// File: rtl/mcu_mem_glue.sv
module mcu_mem_glue #(
  parameter int RST_HOLD = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ad_in,
  input  logic       ale,
  input  logic [7:0] hi_addr,
  input  logic       psen_n,
  input  logic       rd_n,
  input  logic       wr_n,
  output logic [7:0] sram_lo_addr,
  output logic [6:0] sram_hi_addr,
  output logic       sram_ce_n,
  output logic       sram_oe_n,
  output logic [6:0] seg,
  output logic       mcu_rst
);

  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] HOLD = CW'(RST_HOLD);

  logic [CW-1:0] hold_cnt;
  logic          wr_q;
  logic          upper, fetch_or_read, any_strobe, ram_sel;

  assign upper         = hi_addr[7];
  assign fetch_or_read = !psen_n || !rd_n;
  assign any_strobe    = fetch_or_read || !wr_n;
  assign ram_sel       = !upper && any_strobe && !mcu_rst;

  assign sram_hi_addr = hi_addr[6:0];
  assign sram_ce_n    = !ram_sel;
  assign sram_oe_n    = !(ram_sel && fetch_or_read && wr_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   sram_lo_addr <= '0;
    else if (ale) sram_lo_addr <= ad_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_q <= 1'b1;
      seg  <= '0;
    end else begin
      wr_q <= wr_n;
      if (!wr_q && wr_n && upper) seg <= ad_in[6:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               hold_cnt <= '0;
    else if (hold_cnt != HOLD) hold_cnt <= hold_cnt + 1'b1;

  assign mcu_rst = (hold_cnt != HOLD);

endmodule

module mcu_mem_glue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] hi_addr,
  input logic       ale,
  input logic       psen_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [7:0] sram_lo_addr,
  input logic       sram_ce_n,
  input logic       sram_oe_n,
  input logic [6:0] seg,
  input logic       mcu_rst
);

  // R1
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ale) |-> $stable(sram_lo_addr));

  // R3
  upper_no_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_addr[7] |-> sram_ce_n);

  // R4
  no_oe_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> sram_oe_n);

  // R5
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psen_n && rd_n && wr_n) |-> (sram_ce_n && sram_oe_n));

  // R7
  seg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_n, 2) |-> $stable(seg));

  // R9
  rst_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mcu_rst |=> !mcu_rst);

  // R10
  rst_blocks_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_rst |-> (sram_ce_n && sram_oe_n));

endmodule

bind mcu_mem_glue mcu_mem_glue_chk u_chk (.*);

// File: tb/mcu_mem_glue_test.sv
module mcu_mem_glue_test;

  localparam int HOLD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ad_in, hi_addr;
  logic       ale, psen_n, rd_n, wr_n;
  logic [7:0] sram_lo_addr;
  logic [6:0] sram_hi_addr, seg;
  logic       sram_ce_n, sram_oe_n, mcu_rst;

  int checks = 0;
  int fails  = 0;

  mcu_mem_glue #(.RST_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ale(ale), .hi_addr(hi_addr),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .sram_lo_addr(sram_lo_addr),
    .sram_hi_addr(sram_hi_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .seg(seg), .mcu_rst(mcu_rst));

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    ale = 1'b0; psen_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic reset_seq();
    @(negedge clk);
    rst_n = 1'b0; idle(); ad_in = 8'h00; hi_addr = 8'h00;
    #1;
    check("R8 seg in reset", 16'(seg), 16'h0);
    check("R8 lo addr in reset", 16'(sram_lo_addr), 16'h0);
    check("R9 mcu_rst in reset", 16'(mcu_rst), 16'h1);
    @(negedge clk);
    rst_n = 1'b1;
    psen_n = 1'b0;
    #1;
    check("R10 ce_n while mcu_rst", 16'(sram_ce_n), 16'h1);
    check("R10 oe_n while mcu_rst", 16'(sram_oe_n), 16'h1);
    psen_n = 1'b1;
    for (int i = 0; i < HOLD - 1; i++) @(negedge clk);
    check("R9 mcu_rst one edge before end", 16'(mcu_rst), 16'h1);
    @(negedge clk);
    check("R9 mcu_rst released", 16'(mcu_rst), 16'h0);
    repeat (3) @(negedge clk);
    check("R9 mcu_rst stays low", 16'(mcu_rst), 16'h0);
  endtask

  task automatic latch_test(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ale = 1'b1; ad_in = a;
    @(negedge clk);
    check("R1 low byte captured", 16'(sram_lo_addr), 16'(a));
    ale = 1'b0; ad_in = d;
    @(negedge clk);
    check("R1 low byte held after ale", 16'(sram_lo_addr), 16'(a));
    @(negedge clk);
    check("R1 low byte held later", 16'(sram_lo_addr), 16'(a));
  endtask

  task automatic decode_test();
    @(negedge clk);
    hi_addr = 8'h12; psen_n = 1'b0; #1;
    check("R2 hi addr pass", 16'(sram_hi_addr), 16'h12);
    check("R3 ce_n on fetch", 16'(sram_ce_n), 16'h0);
    check("R4 oe_n on fetch", 16'(sram_oe_n), 16'h0);
    psen_n = 1'b1; rd_n = 1'b0; #1;
    check("R3 ce_n on read", 16'(sram_ce_n), 16'h0);
    check("R4 oe_n on read", 16'(sram_oe_n), 16'h0);
    rd_n = 1'b1; wr_n = 1'b0; #1;
    check("R3 ce_n on write", 16'(sram_ce_n), 16'h0);
    check("R4 oe_n off on write", 16'(sram_oe_n), 16'h1);
    wr_n = 1'b1; hi_addr = 8'hF3; rd_n = 1'b0; #1;
    check("R2 bit7 dropped", 16'(sram_hi_addr), 16'h73);
    check("R3 ce_n upper half", 16'(sram_ce_n), 16'h1);
    check("R4 oe_n upper half", 16'(sram_oe_n), 16'h1);
    rd_n = 1'b1; hi_addr = 8'h05; #1;
    check("R5 ce_n idle", 16'(sram_ce_n), 16'h1);
    check("R5 oe_n idle", 16'(sram_oe_n), 16'h1);
  endtask

  task automatic write_test(input logic [7:0] hi, input logic [7:0] d, input logic [6:0] exp_seg, input string req);
    @(negedge clk);
    hi_addr = hi; ad_in = d; wr_n = 1'b0; #1;
    check({req, " ce_n during write"}, 16'(sram_ce_n), 16'(!hi[7] ? 1'b0 : 1'b1));
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    check({req, " seg after write"}, 16'(seg), 16'(exp_seg));
    hi_addr = 8'h00; ad_in = 8'h00;
    @(negedge clk);
    check({req, " seg held"}, 16'(seg), 16'(exp_seg));
  endtask

  task automatic upper_read_test(input logic [6:0] exp_seg);
    @(negedge clk);
    hi_addr = 8'h80; ad_in = 8'h3C; rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 upper read leaves seg", 16'(seg), 16'(exp_seg));
    hi_addr = 8'h00;
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); ad_in = 8'h00; hi_addr = 8'h00;
    reset_seq();
    latch_test(8'h5A, 8'hC3);
    latch_test(8'hA5, 8'h0F);
    decode_test();
    write_test(8'h80, 8'h7F, 7'h7F, "R6");
    write_test(8'hFF, 8'hA5, 7'h25, "R6");
    write_test(8'h00, 8'h11, 7'h25, "R7");
    upper_read_test(7'h25);
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R8 seg cleared by reset", 16'(seg), 16'h0);
    check("R9 mcu_rst reasserted", 16'(mcu_rst), 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule